// File: doc/BRIEF.md
# Tape Controller Command and Status Front End

This block sits between a 16-bit host I/O bus and the operation sequencer of a nine-track tape controller that serves four drives. The host writes a command word. The block checks that word against the live state of the drive it addresses and then either holds it as accepted or raises a reject bit. When the host later sets control, an accepted command produces a single-cycle start pulse towards the sequencer. That pulse carries the function code and the drive number.

The block keeps the controller-owned status bits: busy, reject, odd byte count, end of file, timing error and parity error. It combines these with live per-drive signals into the status word that the host reads. When the sequencer finishes, it returns a done pulse together with result bits. A clear command skips every acceptance check. It resets the controller state and tells the sequencer to abort. A build option adds the high-density indication and the selected-unit field to the status word.

Top module: `tape_cmd_stat`

## Requirements
- R1: After reset, every controller-owned status bit is 0, the selected drive is 0, no command is held, `host_flag` is 1 and neither `start_pulse` nor `abort_pulse` is high.
- R2: A command whose low byte is octal 110 (clear) is always accepted, even while busy, and it clears the reject bit. If control is then set, all controller status bits (busy included) go to 0, the held command is discarded, `abort_pulse` is high for one cycle and no start is issued.
- R3: While the controller is busy, any command other than clear sets reject (status bit 3) and leaves the selected drive unchanged.
- R4: When command bit 8 is set and the controller is not busy, bits 12:9 choose the drive: values 0-1 choose 0, 2-3 choose 1, 4-7 choose 2 and 8-15 choose 3. The new selection holds even if the same command is rejected.
- R5: A command is rejected if any of these holds for the newly selected drive: bit 0 (motion) is set and the drive is active; bit 5 (reverse) is set and the drive is at BOT; bit 3 (write) is set and the drive is online and write-locked. Every new command first clears reject.
- R6: The controller-owned status bits sit at these positions: 11 odd, 8 busy, 7 end of file, 4 timing, 3 reject, 1 parity. Bit 12 reads 0.
- R7: The drive bits come from the selected drive at read time. Bit 10 is rewinding, 6 is BOT and 5 is EOT. Bit 9 (transport busy) is active or offline. Bit 2 is online and write-locked. Bit 0 (local) is offline.
- R8: With `HIGH_DENSITY`=1, bit 15 reads 1 and bits 14:13 show the selected drive. With `HIGH_DENSITY`=0, those bits read 0.
- R9: Setting control while an accepted, non-clear command is held and the controller is idle does four things: it gives exactly one cycle of `start_pulse` with the function code and drive number, it sets busy, it clears the other controller status bits, and it clears `host_flag`.
- R10: A command that was rejected never produces a start pulse, however often control is set.
- R11: A `seq_done` pulse clears busy, sets `host_flag` and ORs `seq_res` into the status: bit 4 goes to odd, bit 3 to end of file, bit 2 to timing, bit 1 to parity and bit 0 to reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Host writes a command word this cycle |
| cmd_wdata | input | 16 | Command word |
| ctl_set | input | 1 | Host sets control (go) |
| seq_done | input | 1 | Sequencer finished the running operation |
| seq_res | input | 5 | Result bits {odd, eof, timing, parity, reject} |
| drv_online | input | 4 | Per-drive online |
| drv_active | input | 4 | Per-drive operation in progress |
| drv_wlock | input | 4 | Per-drive write lock |
| drv_bot | input | 4 | Per-drive at beginning of tape |
| drv_eot | input | 4 | Per-drive at end of tape |
| drv_rew | input | 4 | Per-drive rewinding |
| stat_word | output | 16 | Status word for the host |
| host_flag | output | 1 | Host-facing completion flag |
| start_pulse | output | 1 | One-cycle start to the sequencer |
| start_func | output | 8 | Function code carried with the start |
| start_unit | output | 2 | Drive number carried with the start |
| abort_pulse | output | 1 | One-cycle abort after a clear |

## Verification
Command checks, selection changes and the reject bit are registered on the edge that takes `cmd_wr`. The live drive bits are combinational and show in the same cycle as the input change. `start_pulse`, `abort_pulse`, busy and `host_flag` change on the edge that takes `ctl_set`, and `start_pulse` returns low one edge later. A `seq_done` takes effect on the edge that takes it. Inputs are driven on falling edges and outputs are sampled on the next falling edge, one register stage later. The one exception is drive-state checks, which are sampled a nanosecond after the change.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
   // status word bit positions (host software decodes these)
   localparam int ST_HD      = 15;
   localparam int ST_UNIT_LO = 13;
   localparam int ST_ODD     = 11;
   localparam int ST_REW     = 10;
   localparam int ST_TBSY    = 9;
   localparam int ST_BUSY    = 8;
   localparam int ST_EOF     = 7;
   localparam int ST_BOT     = 6;
   localparam int ST_EOT     = 5;
   localparam int ST_TIM     = 4;
   localparam int ST_REJ     = 3;
   localparam int ST_WLK     = 2;
   localparam int ST_PAR     = 1;
   localparam int ST_LOC     = 0;

   // command word fields
   localparam int CB_MOTION  = 0;
   localparam int CB_WRITE   = 3;
   localparam int CB_REVERSE = 5;
   localparam int CB_CHSEL   = 8;
   localparam int CB_SEL_LO  = 9;
   localparam int SEL_CODE_W = 4;

   localparam logic [7:0] FN_CLEAR = 8'o110;

   typedef struct packed {
      logic odd;
      logic eof;
      logic tim;
      logic par;
      logic rej;
   } res_bits_t;
endpackage

// File: rtl/tcs_sel_map.sv
module tcs_sel_map #(
   parameter int CODE_W = 4,
   parameter int UNIT_W = 2
) (
   input  logic [CODE_W-1:0] code,
   output logic [UNIT_W-1:0] unit
);
   // highest set bit wins; codes 0 and 1 both give unit 0
   always_comb begin
      unit = '0;
      for (int i = 1; i < CODE_W; i++) begin
         if (code[i]) unit = UNIT_W'(i);
      end
   end
endmodule

// File: rtl/tcs_cmd_check.sv
module tcs_cmd_check
   import tcs_pkg::*;
#(
   parameter int NDRV   = 4,
   parameter int UNIT_W = 2
) (
   input  logic [15:0]       cmd,
   input  logic              busy,
   input  logic [UNIT_W-1:0] cur_sel,
   input  logic [NDRV-1:0]   drv_online,
   input  logic [NDRV-1:0]   drv_active,
   input  logic [NDRV-1:0]   drv_wlock,
   input  logic [NDRV-1:0]   drv_bot,
   output logic              is_clear,
   output logic [UNIT_W-1:0] next_sel,
   output logic              reject
);
   generate
      if (NDRV != 4) begin : g_bad_ndrv
         $error("tcs_cmd_check: selection map needs exactly four drives");
      end
   endgenerate

   logic [UNIT_W-1:0] mapped;
   logic              wprot;
   logic              unused_hi;

   assign unused_hi = ^cmd[15:CB_SEL_LO+SEL_CODE_W];

   tcs_sel_map #(.CODE_W(SEL_CODE_W), .UNIT_W(UNIT_W)) u_map (
      .code (cmd[CB_SEL_LO +: SEL_CODE_W]),
      .unit (mapped)
   );

   always_comb begin
      is_clear = (cmd[7:0] == FN_CLEAR);
      next_sel = (!is_clear && !busy && cmd[CB_CHSEL]) ? mapped : cur_sel;
      wprot    = drv_online[next_sel] & drv_wlock[next_sel];
      reject   = !is_clear &&
                 (busy ||
                  (cmd[CB_MOTION]  && drv_active[next_sel]) ||
                  (cmd[CB_REVERSE] && drv_bot[next_sel]) ||
                  (cmd[CB_WRITE]   && wprot));
   end
endmodule

// File: rtl/tcs_stat_mux.sv
module tcs_stat_mux
   import tcs_pkg::*;
#(
   parameter int NDRV         = 4,
   parameter int UNIT_W       = 2,
   parameter int HIGH_DENSITY = 1
) (
   input  logic [UNIT_W-1:0] sel,
   input  res_bits_t         ctl_bits,
   input  logic              busy,
   input  logic [NDRV-1:0]   drv_online,
   input  logic [NDRV-1:0]   drv_active,
   input  logic [NDRV-1:0]   drv_wlock,
   input  logic [NDRV-1:0]   drv_bot,
   input  logic [NDRV-1:0]   drv_eot,
   input  logic [NDRV-1:0]   drv_rew,
   output logic [15:0]       stat
);
   generate
      if (HIGH_DENSITY != 0 && HIGH_DENSITY != 1) begin : g_bad_hd
         $error("tcs_stat_mux: HIGH_DENSITY must be 0 or 1");
      end
   endgenerate

   logic [15:0] base;
   logic        onl;

   always_comb begin
      onl            = drv_online[sel];
      base           = '0;
      base[ST_ODD]   = ctl_bits.odd;
      base[ST_REW]   = drv_rew[sel];
      base[ST_TBSY]  = drv_active[sel] | ~onl;
      base[ST_BUSY]  = busy;
      base[ST_EOF]   = ctl_bits.eof;
      base[ST_BOT]   = drv_bot[sel];
      base[ST_EOT]   = drv_eot[sel];
      base[ST_TIM]   = ctl_bits.tim;
      base[ST_REJ]   = ctl_bits.rej;
      base[ST_WLK]   = onl & drv_wlock[sel];
      base[ST_PAR]   = ctl_bits.par;
      base[ST_LOC]   = ~onl;
   end

   generate
      if (HIGH_DENSITY == 1) begin : g_hd
         always_comb begin
            stat                          = base;
            stat[ST_HD]                   = 1'b1;
            stat[ST_UNIT_LO +: UNIT_W]    = sel;
         end
      end else begin : g_ld
         assign stat = base;
      end
   endgenerate
endmodule

// File: rtl/tape_cmd_stat.sv
module tape_cmd_stat
   import tcs_pkg::*;
#(
   parameter int NDRV         = 4,
   parameter int HIGH_DENSITY = 1,
   localparam int UNIT_W      = $clog2(NDRV)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [15:0]       cmd_wdata,
   input  logic              ctl_set,
   input  logic              seq_done,
   input  logic [4:0]        seq_res,
   input  logic [NDRV-1:0]   drv_online,
   input  logic [NDRV-1:0]   drv_active,
   input  logic [NDRV-1:0]   drv_wlock,
   input  logic [NDRV-1:0]   drv_bot,
   input  logic [NDRV-1:0]   drv_eot,
   input  logic [NDRV-1:0]   drv_rew,
   output logic [15:0]       stat_word,
   output logic              host_flag,
   output logic              start_pulse,
   output logic [7:0]        start_func,
   output logic [UNIT_W-1:0] start_unit,
   output logic              abort_pulse
);
   logic [7:0]        fn_q;
   logic              held_q;
   logic [UNIT_W-1:0] sel_q;
   logic              busy_q;
   res_bits_t         ctl_q;
   res_bits_t         res_in;
   logic              chk_clear;
   logic              chk_reject;
   logic [UNIT_W-1:0] chk_sel;

   assign res_in = res_bits_t'(seq_res);

   tcs_cmd_check #(.NDRV(NDRV), .UNIT_W(UNIT_W)) u_chk (
      .cmd        (cmd_wdata),
      .busy       (busy_q),
      .cur_sel    (sel_q),
      .drv_online (drv_online),
      .drv_active (drv_active),
      .drv_wlock  (drv_wlock),
      .drv_bot    (drv_bot),
      .is_clear   (chk_clear),
      .next_sel   (chk_sel),
      .reject     (chk_reject)
   );

   tcs_stat_mux #(.NDRV(NDRV), .UNIT_W(UNIT_W), .HIGH_DENSITY(HIGH_DENSITY)) u_stat (
      .sel        (sel_q),
      .ctl_bits   (ctl_q),
      .busy       (busy_q),
      .drv_online (drv_online),
      .drv_active (drv_active),
      .drv_wlock  (drv_wlock),
      .drv_bot    (drv_bot),
      .drv_eot    (drv_eot),
      .drv_rew    (drv_rew),
      .stat       (stat_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fn_q        <= '0;
         held_q      <= 1'b0;
         sel_q       <= '0;
         busy_q      <= 1'b0;
         ctl_q       <= '0;
         host_flag   <= 1'b1;
         start_pulse <= 1'b0;
         start_func  <= '0;
         start_unit  <= '0;
         abort_pulse <= 1'b0;
      end else begin
         start_pulse <= 1'b0;
         abort_pulse <= 1'b0;
         if (cmd_wr) begin
            fn_q      <= cmd_wdata[7:0];
            held_q    <= 1'b1;
            sel_q     <= chk_sel;
            ctl_q.rej <= chk_reject;
         end
         if (seq_done) begin
            busy_q    <= 1'b0;
            host_flag <= 1'b1;
            ctl_q     <= ctl_q | res_in;
         end
         if (ctl_set) begin
            if (fn_q == FN_CLEAR) begin
               fn_q        <= '0;
               held_q      <= 1'b0;
               busy_q      <= 1'b0;
               ctl_q       <= '0;
               abort_pulse <= 1'b1;
            end else if (held_q && !ctl_q.rej && !busy_q) begin
               start_pulse <= 1'b1;
               start_func  <= fn_q;
               start_unit  <= sel_q;
               busy_q      <= 1'b1;
               ctl_q       <= '0;
               host_flag   <= 1'b0;
               held_q      <= 1'b0;
            end
         end
      end
   end

   // R9: start lasts one cycle and coincides with busy and a cleared flag
   a_r9_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |=> !start_pulse);
   a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (busy_q && !host_flag));
   // R3: busy rejects non-clear commands and keeps the selection
   a_r3_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy_q && cmd_wdata[7:0] != FN_CLEAR && !seq_done && !ctl_set)
      |=> ctl_q.rej);
   a_r3_sel_held: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && busy_q && cmd_wdata[7:0] != FN_CLEAR) |=> $stable(sel_q));
   // R2: clear is never rejected
   a_r2_clear_ok: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_wdata[7:0] == FN_CLEAR && !seq_done) |=> !ctl_q.rej);
   // R10: no start while reject stands
   a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_set && ctl_q.rej) |=> !start_pulse);
   // R11: completion frees the controller
   a_r11_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && !ctl_set) |=> (!busy_q && host_flag));
endmodule

// File: tb/tape_cmd_stat_test.sv
`timescale 1ns/1ps
module tape_cmd_stat_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_wr;
   logic [15:0] cmd_wdata;
   logic        ctl_set;
   logic        seq_done;
   logic [4:0]  seq_res;
   logic [3:0]  drv_online, drv_active, drv_wlock, drv_bot, drv_eot, drv_rew;
   logic [15:0] stat_word;
   logic        host_flag, start_pulse, abort_pulse;
   logic [7:0]  start_func;
   logic [1:0]  start_unit;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   tape_cmd_stat uut (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .ctl_set(ctl_set), .seq_done(seq_done), .seq_res(seq_res),
      .drv_online(drv_online), .drv_active(drv_active), .drv_wlock(drv_wlock),
      .drv_bot(drv_bot), .drv_eot(drv_eot), .drv_rew(drv_rew),
      .stat_word(stat_word), .host_flag(host_flag), .start_pulse(start_pulse),
      .start_func(start_func), .start_unit(start_unit), .abort_pulse(abort_pulse)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(input int nib, input bit chs, input logic [7:0] fn);
      return {3'b000, 4'(nib), chs, fn};
   endfunction

   task automatic idle_drives();
      drv_online = 4'hF; drv_active = '0; drv_wlock = '0;
      drv_bot = '0; drv_eot = '0; drv_rew = '0;
   endtask

   task automatic wr(input logic [15:0] d);
      @(negedge clk); cmd_wr = 1'b1; cmd_wdata = d;
      @(negedge clk); cmd_wr = 1'b0;
   endtask

   task automatic go();
      @(negedge clk); ctl_set = 1'b1;
      @(negedge clk); ctl_set = 1'b0;
   endtask

   task automatic done(input logic [4:0] r);
      @(negedge clk); seq_done = 1'b1; seq_res = r;
      @(negedge clk); seq_done = 1'b0; seq_res = '0;
   endtask

   task automatic t_reset();
      chk("R1 status", stat_word, 32'h8000);
      chk("R1 flag", host_flag, 1);
      chk("R1 start", start_pulse, 0);
      chk("R1 abort", abort_pulse, 0);
   endtask

   task automatic t_live();
      drv_online[0] = 1'b0; #1;
      chk("R7 offline", stat_word, 32'h8201);
      drv_online[0] = 1'b1; drv_wlock[0] = 1'b1; #1;
      chk("R7 wlock", stat_word, 32'h8004);
      drv_wlock[0] = 1'b0; drv_rew[0] = 1'b1; drv_eot[0] = 1'b1; #1;
      chk("R7 rew eot", stat_word, 32'h8420);
      idle_drives(); #1;
   endtask

   task automatic t_select();
      wr(mk(5, 1, 8'o023));  chk("R4 map 5", stat_word, 32'hC000);
      wr(mk(1, 1, 8'o023));  chk("R4 map 1", stat_word, 32'h8000);
      wr(mk(3, 1, 8'o023));  chk("R4 map 3", stat_word, 32'hA000);
      wr(mk(12, 1, 8'o023)); chk("R8 map 12", stat_word, 32'hE000);
      wr(mk(2, 0, 8'o023));  chk("R4 no chsel", stat_word, 32'hE000);
   endtask

   task automatic t_rej_motion();
      wr(mk(0, 1, 8'o003)); chk("R5 idle ok", stat_word, 32'h8000);
      drv_active[3] = 1'b1;
      wr(mk(8, 1, 8'o023)); chk("R5 motion rej", stat_word, 32'hE208);
      go(); chk("R10 no start", start_pulse, 0);
      idle_drives(); #1;
      chk("R6 rej kept", stat_word, 32'hE008);
   endtask

   task automatic t_rej_rev();
      drv_bot[1] = 1'b1;
      wr(mk(2, 1, 8'o041)); chk("R5 reverse rej", stat_word, 32'hA048);
      wr(mk(2, 1, 8'o003)); chk("R5 forward ok", stat_word, 32'hA040);
      idle_drives();
   endtask

   task automatic t_rej_write();
      drv_wlock[0] = 1'b1;
      wr(mk(0, 1, 8'o031)); chk("R5 write rej", stat_word, 32'h800C);
      idle_drives();
   endtask

   task automatic t_start();
      wr(mk(4, 1, 8'o031)); chk("R9 accepted", stat_word, 32'hC000);
      go();
      chk("R9 start", start_pulse, 1);
      chk("R9 func", start_func, 32'o031);
      chk("R9 unit", start_unit, 2);
      chk("R9 busy", stat_word, 32'hC100);
      chk("R9 flag", host_flag, 0);
      @(negedge clk); chk("R9 one cycle", start_pulse, 0);
   endtask

   task automatic t_busy();
      wr(mk(8, 1, 8'o023)); chk("R3 busy rej", stat_word, 32'hC108);
      go(); chk("R3 no start", start_pulse, 0);
   endtask

   task automatic t_clear();
      wr(mk(0, 0, 8'o110)); chk("R2 clear accepted", stat_word, 32'hC100);
      go();
      chk("R2 abort", abort_pulse, 1);
      chk("R2 status zero", stat_word, 32'hC000);
      chk("R2 no start", start_pulse, 0);
      go(); chk("R2 cmd gone", start_pulse, 0);
   endtask

   task automatic t_done();
      wr(mk(0, 1, 8'o023)); chk("R11 prep", stat_word, 32'h8000);
      go();
      chk("R11 start", start_pulse, 1);
      chk("R11 func", start_func, 32'o023);
      chk("R11 unit", start_unit, 0);
      done(5'b11000);
      chk("R11 odd eof", stat_word, 32'h8880);
      chk("R11 flag", host_flag, 1);
      wr(mk(0, 0, 8'o023)); chk("R6 kept", stat_word, 32'h8880);
      go(); chk("R9 clears bits", stat_word, 32'h8100);
      done(5'b00111);
      chk("R11 tim par rej", stat_word, 32'h801A);
   endtask

   initial begin
      rst_n = 1'b0; cmd_wr = 1'b0; cmd_wdata = '0; ctl_set = 1'b0;
      seq_done = 1'b0; seq_res = '0; idle_drives();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_live();
      t_select();
      t_rej_motion();
      t_rej_rev();
      t_rej_write();
      t_start();
      t_busy();
      t_clear();
      t_done();
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule